// File: doc/BRIEF.md
# Tiled Surface Start-Address Calculator

This block turns a surface description into the register values a copy engine needs in order to begin a transfer at an arbitrary pixel inside a block-tiled surface. The description gives a 40-bit base address (an 8-bit high part and a 32-bit low part), a 12-bit tile-mode word, the surface width and height in pixels, the pixel offsets along x, y and z, and the number of bytes per pixel. The block decodes the tile mode into power-of-two shifts for the tile width in bytes, the tile height in rows and the tile depth in slices. It splits the byte offset along each axis into a tile index and a position inside the tile. It then combines these into an adjusted start address, a tile-row pitch, a Y-tile configuration word, a YZ tile-size field and a wide-tile flag.

A linear mode bypasses the tiling arithmetic. In that mode the base address and the pitch given by the caller pass straight through.

Each calculation is framed by a one-cycle `start` pulse. All inputs are captured on the `start` edge. The results appear two clock edges later, together with a one-cycle `done` pulse, and they are held until the next calculation finishes.

Top module: `tiled_addr_calc`

## Requirements
- R1: While reset is held, `done`, `wide_tile` and every result word read zero.
- R2: A `start` pulse sampled on clock edge N produces `done` high for exactly one cycle after edge N+2, and `done` is never high without such a `start`.
- R3: Tile-mode bits [3:0] equal to 4'hE select a 16-byte tile width (shift Tp=4) and clear `wide_tile`. Any other value selects a 64-byte tile width (Tp=6) and sets `wide_tile`. Bits [7:4]+2 give the row shift Th, and bits [11:8] give the slice shift Td.
- R4: In tiled mode, `start_lo` is the low 32 bits of the 40-bit sum base + off. Here off is taken mod 2^32 and is ((Tz·nTy·nTx + Ty·nTx + Tx) << (Tp+Th+Td)) + (Tzo << (Tp+Th)) + (Tyo << Tp) + Txo. The terms are defined as follows:
  - xb = x·bpp, Tx = xb>>Tp and Txo = xb mod 2^Tp.
  - Ty, Tyo, Tz and Tzo are the same split of y by Th and of z by Td.
  - nTx = ceil(width·bpp / 2^Tp) and nTy = ceil(height / 2^Th).
- R5: The carry out of the low-word addition propagates into the high address byte, which wraps modulo 2^8. The resulting high byte appears in `hi_cfg[23:16]`.
- R6: In tiled mode, `pitch_out` = ((nTx − 1) << (Tp+Th+Td)) mod 2^32.
- R7: In tiled mode, `ytile_cfg` = ((2^Th << 12) | (2^Th − Tyo)) mod 2^32.
- R8: In tiled mode, `hi_cfg` = (high byte << 16) OR ((2^(Th−2) << Td) mod 2^32).
- R9: In linear mode, the outputs are as follows:
  - `start_lo` equals `base_lo`.
  - `pitch_out` equals `pitch_in` zero-extended.
  - `hi_cfg` equals `base_hi << 16`.
  - `ytile_cfg` is zero and `wide_tile` is low.
- R10: The results change only in the cycle in which `done` is high, and otherwise hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request; all inputs are captured with it |
| linear | input | 1 | 1 = linear surface, 0 = block-tiled |
| tile_mode | input | 12 | Tile-shift nibbles: [3:0] width, [7:4] height, [11:8] depth |
| base_hi | input | 8 | Base address bits 39:32 |
| base_lo | input | 32 | Base address bits 31:0 |
| pitch_in | input | 19 | Row pitch used in linear mode |
| width_px | input | 19 | Surface width in pixels |
| height_px | input | 13 | Surface height in rows |
| x_px | input | 19 | Start x offset in pixels |
| y_px | input | 13 | Start y offset in rows |
| z_px | input | 12 | Start z offset in slices |
| bytes_pp | input | 5 | Bytes per pixel |
| done | output | 1 | One-cycle result strobe |
| start_lo | output | 32 | Adjusted start address bits 31:0 |
| hi_cfg | output | 32 | High address byte at [23:16], with the YZ tile-size field OR-ed in |
| pitch_out | output | 32 | Tile-row pitch, or the linear pitch |
| ytile_cfg | output | 32 | Y-tile configuration word |
| wide_tile | output | 1 | 64-byte tile width selected |

## Verification
The assertions take `start` to be a single-cycle pulse, so that each pulse is matched by exactly one `done` two edges later. They also take inputs to be sampled only on the `start` edge, which means no assertion depends on input stability between requests. The pitch-alignment property applies only when the total tile shift is below 32, because a larger shift legitimately drives the pitch to zero. The stimulus keeps to these assumptions: it raises `start` for one cycle, waits for the result before the next request, and sweeps the tile-mode nibbles across both width shifts, several row and depth shifts, and offsets that cross tile boundaries. It keeps every product small enough that the bench's 64-bit reference and the 32-bit datapath agree.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int WORD_W  = 32;
  localparam int SHIFT_W = 6;

  typedef logic [WORD_W-1:0]  word_t;
  typedef logic [SHIFT_W-1:0] shamt_t;

  typedef struct packed {
    shamt_t tp;
    shamt_t th;
    shamt_t td;
    logic   wide;
  } tile_shift_t;

  // 2^s in a 32-bit word; zero once s reaches the word width
  function automatic word_t pow2(input shamt_t s);
    return word_t'(1) << s;
  endfunction

  function automatic word_t low_mask(input shamt_t s);
    return pow2(s) - word_t'(1);
  endfunction

  // ceil(v / 2^s)
  function automatic word_t ceil_shift(input word_t v, input shamt_t s);
    return (v + low_mask(s)) >> s;
  endfunction

  function automatic word_t ytile_word(input shamt_t th, input word_t tyo);
    return (pow2(th) << 12) | (pow2(th) - tyo);
  endfunction

  function automatic word_t yz_field(input shamt_t th, input shamt_t td);
    return pow2(th - shamt_t'(2)) << td;
  endfunction
endpackage

// File: rtl/tsa_mode_decode.sv
module tsa_mode_decode
  import tsa_pkg::*;
#(
  parameter int MODE_W = 12
) (
  input  logic [MODE_W-1:0] mode,
  output tile_shift_t       shifts
);
  localparam logic [3:0] NARROW_CODE = 4'hE;

  always_comb begin
    shifts.wide = (mode[3:0] != NARROW_CODE);
    shifts.tp   = shifts.wide ? shamt_t'(6) : shamt_t'(4);
    shifts.th   = shamt_t'(mode[7:4]) + shamt_t'(2);
    shifts.td   = shamt_t'(mode[11:8]);
  end
endmodule

// File: rtl/tsa_axis_split.sv
module tsa_axis_split
  import tsa_pkg::*;
(
  input  word_t  value,
  input  shamt_t shift,
  output word_t  tile_idx,
  output word_t  in_tile
);
  assign tile_idx = value >> shift;
  assign in_tile  = value & low_mask(shift);
endmodule

// File: rtl/tiled_addr_calc.sv
module tiled_addr_calc
  import tsa_pkg::*;
#(
  parameter int MODE_W  = 12,
  parameter int HI_W    = 8,
  parameter int PITCH_W = 19,
  parameter int XW      = 19,
  parameter int YW      = 13,
  parameter int ZW      = 12,
  parameter int BPP_W   = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               linear,
  input  logic [MODE_W-1:0]  tile_mode,
  input  logic [HI_W-1:0]    base_hi,
  input  logic [31:0]        base_lo,
  input  logic [PITCH_W-1:0] pitch_in,
  input  logic [XW-1:0]      width_px,
  input  logic [YW-1:0]      height_px,
  input  logic [XW-1:0]      x_px,
  input  logic [YW-1:0]      y_px,
  input  logic [ZW-1:0]      z_px,
  input  logic [BPP_W-1:0]   bytes_pp,
  output logic               done,
  output logic [31:0]        start_lo,
  output logic [31:0]        hi_cfg,
  output logic [31:0]        pitch_out,
  output logic [31:0]        ytile_cfg,
  output logic               wide_tile
);
  localparam int NAXES  = 3;
  localparam int FULL_W = 32 + HI_W;
  localparam int HI_POS = 16;

  // ---------------- stage 1: decode and split ----------------
  tile_shift_t dec_sh;
  word_t       byte_x, byte_w;
  word_t       ax_val   [NAXES];
  shamt_t      ax_sh    [NAXES];
  word_t       ax_idx   [NAXES];
  word_t       ax_rem   [NAXES];

  tsa_mode_decode #(.MODE_W(MODE_W)) dec_i (.mode(tile_mode), .shifts(dec_sh));

  assign byte_x = word_t'(x_px) * word_t'(bytes_pp);
  assign byte_w = word_t'(width_px) * word_t'(bytes_pp);

  assign ax_val[0] = byte_x;
  assign ax_val[1] = word_t'(y_px);
  assign ax_val[2] = word_t'(z_px);
  assign ax_sh[0]  = dec_sh.tp;
  assign ax_sh[1]  = dec_sh.th;
  assign ax_sh[2]  = dec_sh.td;

  for (genvar a = 0; a < NAXES; a++) begin : g_axis
    tsa_axis_split split_i (
      .value(ax_val[a]), .shift(ax_sh[a]),
      .tile_idx(ax_idx[a]), .in_tile(ax_rem[a])
    );
  end

  logic              s1_valid, s1_linear;
  tile_shift_t       s1_sh;
  logic [HI_W-1:0]   s1_hi;
  word_t             s1_lo, s1_pitch, s1_ntx, s1_nty;
  word_t             s1_idx [NAXES];
  word_t             s1_rem [NAXES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_linear <= 1'b0;
      s1_sh     <= '0;
      s1_hi     <= '0;
      s1_lo     <= '0;
      s1_pitch  <= '0;
      s1_ntx    <= '0;
      s1_nty    <= '0;
      for (int a = 0; a < NAXES; a++) begin
        s1_idx[a] <= '0;
        s1_rem[a] <= '0;
      end
    end else begin
      s1_valid <= start;
      if (start) begin
        s1_linear <= linear;
        s1_sh     <= dec_sh;
        s1_hi     <= base_hi;
        s1_lo     <= base_lo;
        s1_pitch  <= word_t'(pitch_in);
        s1_ntx    <= ceil_shift(byte_w, dec_sh.tp);
        s1_nty    <= ceil_shift(word_t'(height_px), dec_sh.th);
        for (int a = 0; a < NAXES; a++) begin
          s1_idx[a] <= ax_idx[a];
          s1_rem[a] <= ax_rem[a];
        end
      end
    end
  end

  // ---------------- stage 2: combine ----------------
  shamt_t            sh_yx, sh_all;
  word_t             in_tile_off, tile_num, start_off;
  logic [FULL_W-1:0] full_addr;
  word_t             t_pitch, t_ytile, t_hicfg;

  always_comb begin
    sh_yx       = s1_sh.tp + s1_sh.th;
    sh_all      = sh_yx + s1_sh.td;
    in_tile_off = (s1_rem[2] << sh_yx) + (s1_rem[1] << s1_sh.tp) + s1_rem[0];
    tile_num    = s1_idx[2] * s1_nty * s1_ntx + s1_idx[1] * s1_ntx + s1_idx[0];
    start_off   = (tile_num << sh_all) + in_tile_off;
    full_addr   = {s1_hi, s1_lo} + FULL_W'(start_off);
    t_pitch     = (s1_ntx - word_t'(1)) << sh_all;
    t_ytile     = ytile_word(s1_sh.th, s1_rem[1]);
    t_hicfg     = (word_t'(full_addr[FULL_W-1:32]) << HI_POS) | yz_field(s1_sh.th, s1_sh.td);
  end

  // result tags brought out for the checker
  logic   res_linear;
  shamt_t res_shift_total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done            <= 1'b0;
      start_lo        <= '0;
      hi_cfg          <= '0;
      pitch_out       <= '0;
      ytile_cfg       <= '0;
      wide_tile       <= 1'b0;
      res_linear      <= 1'b0;
      res_shift_total <= '0;
    end else begin
      done <= s1_valid;
      if (s1_valid) begin
        res_linear      <= s1_linear;
        res_shift_total <= sh_all;
        if (s1_linear) begin
          start_lo  <= s1_lo;
          hi_cfg    <= word_t'(s1_hi) << HI_POS;
          pitch_out <= s1_pitch;
          ytile_cfg <= '0;
          wide_tile <= 1'b0;
        end else begin
          start_lo  <= full_addr[31:0];
          hi_cfg    <= t_hicfg;
          pitch_out <= t_pitch;
          ytile_cfg <= t_ytile;
          wide_tile <= s1_sh.wide;
        end
      end
    end
  end
endmodule

// File: rtl/tsa_checker.sv
module tsa_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        done,
  input logic [31:0] start_lo,
  input logic [31:0] hi_cfg,
  input logic [31:0] pitch_out,
  input logic [31:0] ytile_cfg,
  input logic        wide_tile,
  input logic        res_linear,
  input logic [5:0]  res_shift_total
);
  AST_DONE_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> ##2 done);  // R2

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start, 2));  // R2

  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(start_lo) && $stable(hi_cfg) && $stable(pitch_out) && $stable(ytile_cfg)));  // R10

  AST_LINEAR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_linear) |-> (hi_cfg[15:0] == 16'h0 && ytile_cfg == 32'h0 && !wide_tile));  // R9

  AST_PITCH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_linear && res_shift_total < 6'd32)
      |-> ((pitch_out & ((32'd1 << res_shift_total) - 32'd1)) == 32'h0));  // R6
endmodule

bind tiled_addr_calc tsa_checker chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .start_lo(start_lo), .hi_cfg(hi_cfg), .pitch_out(pitch_out),
  .ytile_cfg(ytile_cfg), .wide_tile(wide_tile),
  .res_linear(res_linear), .res_shift_total(res_shift_total)
);

// File: tb/tiled_addr_calc_tb_top.sv
module tiled_addr_calc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, linear = 1'b0;
  logic [11:0] tile_mode = '0;
  logic [7:0]  base_hi = '0;
  logic [31:0] base_lo = '0;
  logic [18:0] pitch_in = '0, width_px = '0, x_px = '0;
  logic [12:0] height_px = '0, y_px = '0;
  logic [11:0] z_px = '0;
  logic [4:0]  bytes_pp = '0;
  logic        done, wide_tile;
  logic [31:0] start_lo, hi_cfg, pitch_out, ytile_cfg;

  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tiled_addr_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .linear(linear), .tile_mode(tile_mode),
    .base_hi(base_hi), .base_lo(base_lo), .pitch_in(pitch_in), .width_px(width_px),
    .height_px(height_px), .x_px(x_px), .y_px(y_px), .z_px(z_px), .bytes_pp(bytes_pp),
    .done(done), .start_lo(start_lo), .hi_cfg(hi_cfg), .pitch_out(pitch_out),
    .ytile_cfg(ytile_cfg), .wide_tile(wide_tile)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic request();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    @(negedge clk);
  endtask

  // reference model, 64-bit arithmetic, reduced at the end
  task automatic run_tiled(input int wsel, input int hn, input int dn, input int k);
    longint tp, th, td, b, xb, tx, txo, ty, tyo, tz, tzo, ntx, nty, off, full, tdiv, hdiv;
    longint e_lo, e_hi, e_pitch, e_yt, e_hic;
    longint bpp_t[4] = '{1, 2, 4, 3};
    longint x_t[4]   = '{0, 37, 100, 513};
    longint y_t[4]   = '{0, 5, 19, 33};
    longint z_t[4]   = '{0, 1, 6, 3};
    longint w_t[4]   = '{64, 100, 257, 31};
    longint h_t[4]   = '{8, 30, 65, 4};
    linear    = 1'b0;
    tile_mode = {4'(dn), 4'(hn), (wsel == 0) ? 4'hE : 4'h3};
    base_hi   = (k == 3) ? 8'hFF : 8'h12;
    base_lo   = (k == 3) ? 32'hFFFF_FFF0 : 32'h0000_1000;
    bytes_pp  = 5'(bpp_t[k]);
    x_px = 19'(x_t[k]); y_px = 13'(y_t[k]); z_px = 12'(z_t[k]);
    width_px = 19'(w_t[k]); height_px = 13'(h_t[k]);
    request();
    tp = (wsel == 0) ? 4 : 6; th = hn + 2; td = dn; b = bpp_t[k];
    tdiv = 64'd1 << tp; hdiv = 64'd1 << th;
    xb = x_t[k] * b;
    tx = xb / tdiv; txo = xb % tdiv;
    ty = y_t[k] / hdiv; tyo = y_t[k] % hdiv;
    tz = z_t[k] / (64'd1 << td); tzo = z_t[k] % (64'd1 << td);
    ntx = (w_t[k] * b + tdiv - 1) / tdiv;
    nty = (h_t[k] + hdiv - 1) / hdiv;
    off = (((tz * nty * ntx + ty * ntx + tx) << (tp + th + td))
          + (tzo << (tp + th)) + (tyo << tp) + txo) & 64'hFFFF_FFFF;
    full = ((longint'(base_hi) << 32) + longint'(base_lo) + off) & 64'hFF_FFFF_FFFF;
    e_lo = full & 64'hFFFF_FFFF;
    e_hi = full >> 32;
    e_pitch = ((ntx - 1) << (tp + th + td)) & 64'hFFFF_FFFF;
    e_yt = ((hdiv << 12) | (hdiv - tyo)) & 64'hFFFF_FFFF;
    e_hic = ((e_hi << 16) | ((64'd1 << (th - 2)) << td)) & 64'hFFFF_FFFF;
    check("R2", "done", longint'(done), 1);
    check("R3", "wide_tile", longint'(wide_tile), (wsel == 0) ? 0 : 1);
    check("R4", "start_lo", longint'(start_lo), e_lo);
    check("R5", "high byte", longint'(hi_cfg[23:16]), e_hi);
    check("R6", "pitch", longint'(pitch_out), e_pitch);
    check("R7", "ytile", longint'(ytile_cfg), e_yt);
    check("R8", "hi_cfg", longint'(hi_cfg), e_hic);
  endtask

  task automatic run_linear(input logic [7:0] hi, input logic [31:0] lo, input logic [18:0] p);
    linear = 1'b1; base_hi = hi; base_lo = lo; pitch_in = p;
    tile_mode = 12'h123; x_px = 19'd77; y_px = 13'd9; z_px = 12'd2; bytes_pp = 5'd4;
    request();
    check("R9", "linear start_lo", longint'(start_lo), longint'(lo));
    check("R9", "linear pitch", longint'(pitch_out), longint'(p));
    check("R9", "linear hi_cfg", longint'(hi_cfg), longint'(hi) << 16);
    check("R9", "linear ytile", longint'(ytile_cfg), 0);
    check("R9", "linear wide", longint'(wide_tile), 0);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] held_lo, held_pitch;
    start = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", "reset done", longint'(done), 0);
    check("R1", "reset start_lo", longint'(start_lo), 0);
    check("R1", "reset hi_cfg", longint'(hi_cfg), 0);
    check("R1", "reset pitch", longint'(pitch_out), 0);
    check("R1", "reset ytile", longint'(ytile_cfg), 0);
    check("R1", "reset wide", longint'(wide_tile), 0);
    start = 1'b0;
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2", "no spurious done", longint'(done), 0);

    for (int w = 0; w < 2; w++)
      for (int hn = 0; hn < 4; hn++)
        for (int dn = 0; dn < 3; dn++)
          for (int k = 0; k < 4; k++)
            run_tiled(w, hn, dn, k);

    // R10: results hold with done low, even while inputs move
    held_lo = start_lo; held_pitch = pitch_out;
    base_lo = 32'hDEAD_0000; x_px = 19'd999; linear = 1'b1;
    repeat (4) @(negedge clk);
    check("R2", "done one cycle only", longint'(done), 0);
    check("R10", "start_lo held", longint'(start_lo), longint'(held_lo));
    check("R10", "pitch held", longint'(pitch_out), longint'(held_pitch));

    run_linear(8'hA5, 32'h1234_5670, 19'd4096);
    run_linear(8'h00, 32'hFFFF_FFFF, 19'h7FFFF);
    run_tiled(1, 3, 2, 3);

    summary();
  end
endmodule